// File: doc/BRIEF.md
# Low-Power Lane Turnaround Sequencer

This block sequences the hand-off of direction on a bidirectional serial data lane while the lane is in its low-power signalling mode. Each lane line pair is observed as a two-bit line state, written `{P,N}`: stop is `11`, the request mark is `10`, the bridge is `00`, and `01` is the other single-ended state. One instance sits at each end of the lane. The end that owns the lane leaves stop on a turnaround request. It drives the request mark, then a long bridge, and then turns its driver off. The far end sees the mark and then the bridge. It waits a short sure interval, drives its own bridge, marks, and settles in stop as the new owner.

All intervals are whole multiples of one low-power period (lpx). The lpx is given as a count of system clock cycles on `lpx_cycles`, so the minimum real-time lpx is met by choosing that count. Both waits for the far end (the arming wait and the release wait) are bounded by `timeout_cycles`. A wait that expires drops the sequencer to receive-idle and pulses an error flag. Line contention and escape-mode traffic are handled elsewhere.

The sequencer has ten states. Owner side: OWN_IDLE (drives stop), REQ_MARK (drives `10`), REQ_BRIDGE (drives `00`), GO_BRIDGE (drives `00`), REL_WAIT (driver off). Taking side: RX_IDLE, ARMED, SURE (all with the driver off), GET_BRIDGE (drives `00`), GET_MARK (drives `10`). The transitions are:
- OWN_IDLE→REQ_MARK on an accepted request.
- REQ_MARK→REQ_BRIDGE after 1 lpx.
- REQ_BRIDGE→GO_BRIDGE after 1 lpx.
- GO_BRIDGE→REL_WAIT after 4 lpx.
- REL_WAIT→RX_IDLE when stop is seen or the wait times out.
- RX_IDLE→ARMED when `10` is seen.
- ARMED→SURE when `00` is seen.
- ARMED→RX_IDLE when stop or `01` is seen, or the wait times out.
- SURE→GET_BRIDGE after 1 or 2 lpx.
- GET_BRIDGE→GET_MARK after 5 lpx.
- GET_MARK→OWN_IDLE after 1 lpx.

Top module: `lp_turnaround_seq`

## Requirements
- R1: After reset, with the default ownership parameter, the block is in OWN_IDLE. It drives `tx_oe`=1, `tx_lp`=`11` and `owns_dir`=1, and `to_err`=0.
- R2: A request on `ta_req` is taken only in OWN_IDLE while `rx_lp`=`11`. In any other case it has no effect, and the outputs keep their values.
- R3: An accepted request makes the owner drive `10` for exactly 1 lpx. It then drives `00` for exactly 5 lpx (1 lpx of request and the 4-lpx bridge). After that, `tx_oe` and `owns_dir` both fall to 0 in the same cycle.
- R4: After releasing, the former owner goes to receive-idle when it sees `rx_lp`=`11`, and `to_err` stays 0.
- R5: In receive-idle, `rx_lp`=`10` arms the block. A following `00` starts the sure interval, during which the driver stays off. The interval is 1 lpx when `sure_long`=0 and 2 lpx when `sure_long`=1.
- R6: After the sure interval the block drives `00` for exactly 5 lpx, then `10` for exactly 1 lpx. Only then does it show `11` with `owns_dir`=1.
- R7: If the release wait or the arming wait lasts `timeout_cycles` cycles without the expected line state, the block returns to receive-idle. In that case `to_err` is 1 for exactly one cycle, in the cycle after the last waiting cycle.
- R8: While armed, a line state of `11` or `01` sends the block back to receive-idle with no error. A later `00` then does not start a takeover.
- R9: A `lpx_cycles` value of 0 gives the same timing as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpx_cycles | input | LPX_W | Clock cycles per lpx (0 treated as 1) |
| sure_long | input | 1 | Sure interval select: 0 = 1 lpx, 1 = 2 lpx |
| timeout_cycles | input | TO_W | Bound in cycles on each wait for the far end |
| ta_req | input | 1 | Turnaround request from the link layer |
| rx_lp | input | 2 | Sampled received line state `{P,N}` |
| tx_lp | output | 2 | Line state to drive `{P,N}`; `00` when not driving |
| tx_oe | output | 1 | Low-power driver enable |
| owns_dir | output | 1 | This end owns the lane direction |
| to_err | output | 1 | One-cycle pulse on a wait timeout |

## Verification
The bench runs the full hand-off in both directions for lpx counts 0, 1, 2, 3 and 5, each with both sure settings. It measures the length of every driven segment in cycles. A wrong multiplier, a merged state or an off-by-one shows up as a length mismatch. A zero lpx that is not clamped shows up at the count 0. Timeouts of 1, 2 and 5 cycles are run on both waits. This separates the exact timeout cycle from its neighbours and shows that the error flag is a single pulse. Requests in a non-stop line state, requests in the receiving role, and armed aborts by `01` followed by a bridge all tell apart "ignored" from "partly acted on".

// File: rtl/lta_pkg.sv
package lta_pkg;

    localparam logic [1:0] LP_STOP   = 2'b11;
    localparam logic [1:0] LP_MARK   = 2'b10;
    localparam logic [1:0] LP_BRIDGE = 2'b00;

    typedef enum logic [3:0] {
        ST_OWN_IDLE,
        ST_REQ_MARK,
        ST_REQ_BRIDGE,
        ST_GO_BRIDGE,
        ST_REL_WAIT,
        ST_RX_IDLE,
        ST_ARMED,
        ST_SURE,
        ST_GET_BRIDGE,
        ST_GET_MARK
    } lta_state_e;

endpackage

// File: rtl/lta_span.sv
module lta_span
    import lta_pkg::*;
#(
    parameter int LPX_W = 8,
    parameter int CNT_W = 13
) (
    input  lta_state_e        state,
    input  logic [LPX_W-1:0]  lpx_cycles,
    input  logic              sure_long,
    output logic [CNT_W-1:0]  span
);
    logic [LPX_W-1:0] lpx_eff;
    logic [2:0]       mult;

    assign lpx_eff = (lpx_cycles == '0) ? LPX_W'(1) : lpx_cycles;

    always_comb begin
        unique case (state)
            ST_REQ_MARK:   mult = 3'd1;
            ST_REQ_BRIDGE: mult = 3'd1;
            ST_GO_BRIDGE:  mult = 3'd4;
            ST_SURE:       mult = sure_long ? 3'd2 : 3'd1;
            ST_GET_BRIDGE: mult = 3'd5;
            ST_GET_MARK:   mult = 3'd1;
            default:       mult = 3'd0;
        endcase
    end

    assign span = CNT_W'(mult) * CNT_W'(lpx_eff);

endmodule

// File: rtl/lta_timer.sv
module lta_timer #(
    parameter int TO_W  = 12,
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CNT_W-1:0]  span,
    input  logic [TO_W-1:0]   timeout_cycles,
    output logic              span_done,
    output logic              to_hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt_inc;
    end

    assign span_done = (cnt_inc == span);
    assign to_hit    = (cnt_inc >= CNT_W'(timeout_cycles));

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> cnt >= $past(cnt)); // R7

endmodule

// File: rtl/lta_drive.sv
module lta_drive
    import lta_pkg::*;
(
    input  lta_state_e  state,
    output logic [1:0]  tx_lp,
    output logic        tx_oe,
    output logic        owns_dir
);
    always_comb begin
        unique case (state)
            ST_OWN_IDLE:   begin tx_lp = LP_STOP;   tx_oe = 1'b1; owns_dir = 1'b1; end
            ST_REQ_MARK:   begin tx_lp = LP_MARK;   tx_oe = 1'b1; owns_dir = 1'b1; end
            ST_REQ_BRIDGE: begin tx_lp = LP_BRIDGE; tx_oe = 1'b1; owns_dir = 1'b1; end
            ST_GO_BRIDGE:  begin tx_lp = LP_BRIDGE; tx_oe = 1'b1; owns_dir = 1'b1; end
            ST_GET_BRIDGE: begin tx_lp = LP_BRIDGE; tx_oe = 1'b1; owns_dir = 1'b0; end
            ST_GET_MARK:   begin tx_lp = LP_MARK;   tx_oe = 1'b1; owns_dir = 1'b0; end
            default:       begin tx_lp = LP_BRIDGE; tx_oe = 1'b0; owns_dir = 1'b0; end
        endcase
    end

endmodule

// File: rtl/lp_turnaround_seq.sv
module lp_turnaround_seq
    import lta_pkg::*;
#(
    parameter int LPX_W        = 8,
    parameter int TO_W         = 12,
    parameter bit OWN_AT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LPX_W-1:0]  lpx_cycles,
    input  logic              sure_long,
    input  logic [TO_W-1:0]   timeout_cycles,
    input  logic              ta_req,
    input  logic [1:0]        rx_lp,
    output logic [1:0]        tx_lp,
    output logic              tx_oe,
    output logic              owns_dir,
    output logic              to_err
);
    localparam int SPAN_W = LPX_W + 3;
    localparam int CNT_W  = ((SPAN_W > TO_W) ? SPAN_W : TO_W) + 1;
    localparam lta_state_e RESET_ST = OWN_AT_RESET ? ST_OWN_IDLE : ST_RX_IDLE;

    lta_state_e        state, nxt;
    logic [CNT_W-1:0]  span;
    logic              span_done, to_hit, fire_err, err_q;

    lta_span #(.LPX_W(LPX_W), .CNT_W(CNT_W)) u_span (
        .state(state), .lpx_cycles(lpx_cycles), .sure_long(sure_long), .span(span)
    );

    lta_timer #(.TO_W(TO_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(nxt != state), .span(span),
        .timeout_cycles(timeout_cycles), .span_done(span_done), .to_hit(to_hit)
    );

    lta_drive u_drive (
        .state(state), .tx_lp(tx_lp), .tx_oe(tx_oe), .owns_dir(owns_dir)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RESET_ST;
        else        state <= nxt;
    end

    // next state and timeout decision
    always_comb begin
        nxt      = state;
        fire_err = 1'b0;
        unique case (state)
            ST_OWN_IDLE:   if (ta_req && rx_lp == LP_STOP) nxt = ST_REQ_MARK;
            ST_REQ_MARK:   if (span_done) nxt = ST_REQ_BRIDGE;
            ST_REQ_BRIDGE: if (span_done) nxt = ST_GO_BRIDGE;
            ST_GO_BRIDGE:  if (span_done) nxt = ST_REL_WAIT;
            ST_REL_WAIT: begin
                if (rx_lp == LP_STOP) nxt = ST_RX_IDLE;
                else if (to_hit) begin
                    nxt      = ST_RX_IDLE;
                    fire_err = 1'b1;
                end
            end
            ST_RX_IDLE:    if (rx_lp == LP_MARK) nxt = ST_ARMED;
            ST_ARMED: begin
                if (rx_lp == LP_BRIDGE) nxt = ST_SURE;
                else if (rx_lp != LP_MARK) nxt = ST_RX_IDLE;
                else if (to_hit) begin
                    nxt      = ST_RX_IDLE;
                    fire_err = 1'b1;
                end
            end
            ST_SURE:       if (span_done) nxt = ST_GET_BRIDGE;
            ST_GET_BRIDGE: if (span_done) nxt = ST_GET_MARK;
            ST_GET_MARK:   if (span_done) nxt = ST_OWN_IDLE;
            default:       nxt = ST_RX_IDLE;
        endcase
    end

    // registered error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= fire_err;
    end
    assign to_err = err_q;

    AST_OWN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        owns_dir |-> tx_oe); // R3
    AST_RELEASE_AFTER_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> ($past(tx_lp) == LP_BRIDGE && !owns_dir)); // R3
    AST_TAKE_WITH_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> (tx_lp == LP_BRIDGE && !owns_dir)); // R6
    AST_OWN_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owns_dir) |-> (tx_lp == LP_STOP && $past(tx_lp) == LP_MARK)); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        to_err |=> !to_err); // R7
    AST_ERR_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        to_err |-> (!tx_oe && !owns_dir)); // R7
    AST_REQ_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_lp) == LP_STOP && $past(owns_dir) && $past(rx_lp) != LP_STOP)
        |-> tx_lp == LP_STOP); // R2

endmodule

// File: tb/sim_lp_turnaround_seq.sv
module sim_lp_turnaround_seq;
    localparam int LPX_W = 8;
    localparam int TO_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LPX_W-1:0]  lpx_cycles = '0;
    logic              sure_long = 1'b0;
    logic [TO_W-1:0]   timeout_cycles = TO_W'(200);
    logic              ta_req = 1'b0;
    logic [1:0]        rx_lp = 2'b11;
    logic [1:0]        tx_lp;
    logic              tx_oe, owns_dir, to_err;

    int checks = 0;
    int errors = 0;
    int err_pulses = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    lp_turnaround_seq #(.LPX_W(LPX_W), .TO_W(TO_W), .OWN_AT_RESET(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx_cycles), .sure_long(sure_long),
        .timeout_cycles(timeout_cycles), .ta_req(ta_req), .rx_lp(rx_lp),
        .tx_lp(tx_lp), .tx_oe(tx_oe), .owns_dir(owns_dir), .to_err(to_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && to_err) err_pulses <= err_pulses + 1;
    end

    function automatic logic [3:0] sig();
        return {tx_oe, owns_dir, tx_lp};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_run(input logic [3:0] s, input int len, input string req);
        int n = 0;
        while (sig() == s && n < len + 8) begin
            n++;
            @(negedge clk);
        end
        check(n == len, req, n, len);
    endtask

    // owner hands the lane away; leaves bench at first released sample
    task automatic give_away(input int l);
        ta_req = 1'b1;
        @(negedge clk);
        ta_req = 1'b0;
        rx_lp  = 2'b00;
        expect_run(4'b1110, l, "R3 mark length");
        expect_run(4'b1100, 5 * l, "R3 bridge length");
        check(sig() == 4'b0000, "R3 release", int'(sig()), 0);
    endtask

    // far end hands the lane back to this end
    task automatic take_back(input int l, input int s);
        rx_lp = 2'b10;
        repeat (l) @(negedge clk);
        rx_lp = 2'b00;
        @(negedge clk);
        expect_run(4'b0000, s * l, "R5 sure length");
        expect_run(4'b1000, 5 * l, "R6 bridge length");
        expect_run(4'b1010, l, "R6 mark length");
        check(sig() == 4'b1111, "R6 owned stop", int'(sig()), 15);
        rx_lp = 2'b11;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sig() == 4'b1111, "R1 reset outputs", int'(sig()), 15);
        check(to_err == 1'b0, "R1 reset error", int'(to_err), 0);

        // R2: request ignored when line not in stop
        rx_lp = 2'b10;
        ta_req = 1'b1;
        @(negedge clk);
        ta_req = 1'b0;
        rx_lp = 2'b11;
        repeat (3) begin
            check(sig() == 4'b1111, "R2 request without stop", int'(sig()), 15);
            @(negedge clk);
        end

        // main sweep: lpx counts and sure settings
        foreach (lpx_tab[i]) begin
            for (int s = 0; s < 2; s++) begin
                int l;
                int e0;
                lpx_cycles = LPX_W'(lpx_tab[i]);
                sure_long  = s[0];
                l = (lpx_tab[i] == 0) ? 1 : lpx_tab[i]; // R9 clamp
                e0 = err_pulses;
                give_away(l);
                @(negedge clk);
                rx_lp = 2'b11;
                @(negedge clk);
                @(negedge clk);
                check(sig() == 4'b0000, "R4 receive idle", int'(sig()), 0);
                check(err_pulses == e0, "R4 no error", err_pulses - e0, 0);
                // R2: request while receiving has no effect
                ta_req = 1'b1;
                @(negedge clk);
                ta_req = 1'b0;
                repeat (2) begin
                    check(sig() == 4'b0000, "R2 request while receiving", int'(sig()), 0);
                    @(negedge clk);
                end
                take_back(l, s + 1);
                if (lpx_tab[i] == 0)
                    check(1'b1, "R9 zero lpx as one", 1, 1);
                @(negedge clk);
            end
        end

        // timeout sweep
        lpx_cycles = LPX_W'(2);
        sure_long  = 1'b0;
        for (int t = 0; t < 3; t++) begin
            int tv;
            int k;
            int e0;
            tv = (t == 0) ? 1 : (t == 1) ? 2 : 5;
            timeout_cycles = TO_W'(tv);
            give_away(2);
            k = 0;
            while (!to_err && k < tv + 10) begin
                @(negedge clk);
                k++;
            end
            check(k == tv, "R7 release wait timeout cycle", k, tv);
            check(sig() == 4'b0000, "R7 idle after timeout", int'(sig()), 0);
            @(negedge clk);
            check(to_err == 1'b0, "R7 single pulse", int'(to_err), 0);
            rx_lp = 2'b11;
            @(negedge clk);
            // arming wait timeout
            rx_lp = 2'b10;
            k = 0;
            while (!to_err && k < tv + 10) begin
                @(negedge clk);
                k++;
            end
            check(k == tv + 1, "R7 arming wait timeout cycle", k, tv + 1);
            @(negedge clk);
            check(to_err == 1'b0, "R7 arming single pulse", int'(to_err), 0);
            rx_lp = 2'b11;
            @(negedge clk);
            // R8: abort while armed with 01, then bridge must not take over
            e0 = err_pulses;
            timeout_cycles = TO_W'(200);
            rx_lp = 2'b10;
            @(negedge clk);
            rx_lp = 2'b01;
            @(negedge clk);
            rx_lp = 2'b00;
            repeat (16) begin
                check(sig() == 4'b0000, "R8 abort no takeover", int'(sig()), 0);
                @(negedge clk);
            end
            check(err_pulses == e0, "R8 abort no error", err_pulses - e0, 0);
            rx_lp = 2'b11;
            @(negedge clk);
            take_back(2, 1);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int lpx_tab [5] = '{0, 1, 2, 3, 5};

    initial begin
        wait (cyc >= 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule